// File: doc/BRIEF.md
# Configurable Pin Interface Cell

This block sits between one group of device pins and the internal logic. A 3-bit mode input sets its role. It can pass the pin straight through to the core, capture it in a register, or hold it in a level-sensitive latch. It can also drive the pin as an output, or act as a bidirectional pin whose driver can be switched off. The pin is modelled as three separate signals: the value seen on the pad, the value driven onto it and the driver enable.

The input register and the latch share one capture clock. A select input picks that clock from two dedicated I/O clocks. The driver enable comes from one of two global enables or from an enable made by a product term. An active-low test enable switches the driver off whatever the other controls say. An active-low reset clears both the register and the latch at once, without waiting for a clock.

In bidirectional mode the core always sees the pad value, so it reads back what the cell drives whenever the driver is on.

Top module: `io_cell_cfg`

## Requirements
- R1: With `mode_i` = 0 (combinational input), `core_in_o` equals `pad_in_i` in the same cycle and `pad_oe_o` is 0.
- R2: With `mode_i` = 1 (registered input), `core_in_o` takes the value of `pad_in_i` at each rising edge of the selected capture clock and keeps it between edges.
- R3: With `mode_i` = 2 (latched input), `core_in_o` follows `pad_in_i` while the selected capture clock is high and holds the last value while that clock is low.
- R4: `clk_sel_i` = 0 selects `clk_a_i` as the capture clock and `clk_sel_i` = 1 selects `clk_b_i`. Edges and levels of the clock that is not selected have no effect.
- R5: With `mode_i` = 3 (output), `pad_out_o` equals `core_out_i`, `pad_oe_o` equals the selected enable, and `core_in_o` is 0.
- R6: `oe_sel_i` = 0 selects `goe_i[0]`, `oe_sel_i` = 1 selects `goe_i[1]`, and `oe_sel_i` = 2 or 3 selects `pt_oe_i`.
- R7: With `mode_i` = 4 (bidirectional), `pad_oe_o` is the selected enable and `core_in_o` equals `pad_in_i` at all times.
- R8: In the input modes (0, 1, 2) and for the unused codes 5, 6 and 7, `pad_oe_o` is 0. The codes 5 to 7 also behave as mode 0.
- R9: While `test_oe_ni` is 0, `pad_oe_o` is 0 in every mode and for every enable selection.
- R10: While `rst_ni` is 0, the input register and the latch are both 0, so `core_in_o` is 0 in modes 1 and 2. The clear happens without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | First dedicated I/O clock |
| clk_b_i | input | 1 | Second dedicated I/O clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the register and the latch |
| mode_i | input | 3 | Cell mode code |
| clk_sel_i | input | 1 | Capture clock select |
| oe_sel_i | input | 2 | Driver enable source select |
| goe_i | input | 2 | Global output enables |
| pt_oe_i | input | 1 | Product-term output enable |
| test_oe_ni | input | 1 | Active-low test enable; forces the driver off |
| pad_in_i | input | WIDTH | Value seen on the pads |
| core_out_i | input | WIDTH | Value from the core to drive onto the pads |
| core_in_o | output | WIDTH | Value delivered to the core |
| pad_out_o | output | WIDTH | Value driven onto the pads |
| pad_oe_o | output | 1 | Pad driver enable |

## Verification
The assertions check the following on every cycle:
- the register update on each capture edge;
- the latch value at the end of each transparent phase;
- the driver staying off in the input and unused modes and while the test enable is low;
- the read-back path in bidirectional mode.

Only the bench scenarios can show the following:
- that the unselected clock is ignored;
- that the enable multiplexer picks each source correctly;
- that reset clears the register and the latch without a clock;
- that the latch follows the pad while open and holds once it closes.

// File: rtl/io_cell_pkg.sv
package io_cell_pkg;

  typedef enum logic [2:0] {
    MODE_COMB_IN = 3'd0,
    MODE_REG_IN  = 3'd1,
    MODE_LAT_IN  = 3'd2,
    MODE_OUT     = 3'd3,
    MODE_BIDIR   = 3'd4
  } io_mode_e;

  function automatic logic mode_drives(input logic [2:0] m);
    return (m == MODE_OUT) || (m == MODE_BIDIR);
  endfunction

endpackage

// File: rtl/io_clk_select.sv
module io_clk_select #(
  parameter int NUM_CLK = 2,
  localparam int SEL_W = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic [NUM_CLK-1:0] clk_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               clk_o
);

  assign clk_o = clk_i[sel_i];

endmodule

// File: rtl/io_oe_select.sv
module io_oe_select #(
  parameter int NUM_GOE = 2,
  localparam int SEL_W = $clog2(NUM_GOE + 1)
) (
  input  logic [NUM_GOE-1:0] goe_i,
  input  logic               pt_oe_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               oe_o
);

  always_comb begin
    oe_o = pt_oe_i;
    for (int k = 0; k < NUM_GOE; k++) begin
      if (sel_i == SEL_W'(k)) oe_o = goe_i[k];
    end
  end

endmodule

// File: rtl/io_in_capture.sv
module io_in_capture #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] reg_q_o,
  output logic [WIDTH-1:0] lat_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_q_o <= '0;
    else         reg_q_o <= d_i;
  end

  // transparent while the capture clock is high
  always_latch begin
    if (!rst_ni)    lat_q_o = '0;
    else if (clk_i) lat_q_o = d_i;
  end

  // R2: register holds the pad value of the previous capture edge
  a_r2_reg_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (reg_q_o == $past(d_i)))
    else $error("a_r2_reg_capture");

  // R3: at the end of the transparent phase the latch matches the pad
  a_r3_latch_close: assert property (@(negedge clk_i) disable iff (!rst_ni)
    lat_q_o == d_i)
    else $error("a_r3_latch_close");

endmodule

// File: rtl/io_cell_cfg.sv
module io_cell_cfg
  import io_cell_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int NUM_GOE = 2,
  localparam int OE_SEL_W = $clog2(NUM_GOE + 1)
) (
  input  logic                clk_a_i,
  input  logic                clk_b_i,
  input  logic                rst_ni,
  input  logic [2:0]          mode_i,
  input  logic                clk_sel_i,
  input  logic [OE_SEL_W-1:0] oe_sel_i,
  input  logic [NUM_GOE-1:0]  goe_i,
  input  logic                pt_oe_i,
  input  logic                test_oe_ni,
  input  logic [WIDTH-1:0]    pad_in_i,
  input  logic [WIDTH-1:0]    core_out_i,
  output logic [WIDTH-1:0]    core_in_o,
  output logic [WIDTH-1:0]    pad_out_o,
  output logic                pad_oe_o
);

  logic             cap_clk;
  logic [WIDTH-1:0] reg_q, lat_q;
  logic             oe_sel;

  io_clk_select #(.NUM_CLK(2)) i_clk_sel (
    .clk_i ({clk_b_i, clk_a_i}),
    .sel_i (clk_sel_i),
    .clk_o (cap_clk)
  );

  io_in_capture #(.WIDTH(WIDTH)) i_capture (
    .clk_i   (cap_clk),
    .rst_ni  (rst_ni),
    .d_i     (pad_in_i),
    .reg_q_o (reg_q),
    .lat_q_o (lat_q)
  );

  io_oe_select #(.NUM_GOE(NUM_GOE)) i_oe_sel (
    .goe_i   (goe_i),
    .pt_oe_i (pt_oe_i),
    .sel_i   (oe_sel_i),
    .oe_o    (oe_sel)
  );

  // unused codes fall back to combinational input
  always_comb begin
    case (mode_i)
      MODE_REG_IN: core_in_o = reg_q;
      MODE_LAT_IN: core_in_o = lat_q;
      MODE_OUT:    core_in_o = '0;
      default:     core_in_o = pad_in_i;
    endcase
  end

  assign pad_out_o = core_out_i;
  assign pad_oe_o  = test_oe_ni & mode_drives(mode_i) & oe_sel;

  // R9: test enable low keeps the driver off
  a_r9_test_oe_off: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !test_oe_ni |-> !pad_oe_o)
    else $error("a_r9_test_oe_off");

  // R8: input-only and unused modes never drive
  a_r8_input_no_drive: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (mode_i != 3'd3 && mode_i != 3'd4) |-> !pad_oe_o)
    else $error("a_r8_input_no_drive");

  // R7: bidirectional mode reads the pad back
  a_r7_bidir_readback: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (mode_i == 3'd4) |-> (core_in_o == pad_in_i))
    else $error("a_r7_bidir_readback");

endmodule

// File: tb/test_io_cell_cfg.sv
module test_io_cell_cfg;

  logic       clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic [2:0] mode = 3'd1;
  logic       clk_sel = 1'b0;
  logic [1:0] oe_sel = 2'd0, goe = 2'd0;
  logic       pt_oe = 1'b0, toe_n = 1'b1;
  logic [3:0] pad_in = 4'hF, core_out = 4'h0;
  logic [3:0] core_in, pad_out;
  logic       pad_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk_a = ~clk_a;

  io_cell_cfg i_io_cell_cfg (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n), .mode_i(mode),
    .clk_sel_i(clk_sel), .oe_sel_i(oe_sel), .goe_i(goe), .pt_oe_i(pt_oe),
    .test_oe_ni(toe_n), .pad_in_i(pad_in), .core_out_i(core_out),
    .core_in_o(core_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] mode;
    logic [1:0] osel;
    logic [1:0] goe;
    logic       pt;
    logic       toe_n;
    logic [3:0] pin;
    logic [3:0] cout;
    logic       exp_oe;
    logic [3:0] exp_in;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 3'd0, 2'd0, 2'b11, 1'b1, 1'b1, 4'hA, 4'h5, 1'b0, 4'hA}, // R1
    '{4'd5, 3'd3, 2'd0, 2'b01, 1'b0, 1'b1, 4'hA, 4'h5, 1'b1, 4'h0}, // R5
    '{4'd6, 3'd3, 2'd1, 2'b01, 1'b1, 1'b1, 4'hA, 4'h6, 1'b0, 4'h0}, // R6 goe[1]
    '{4'd6, 3'd3, 2'd2, 2'b00, 1'b1, 1'b1, 4'h2, 4'h7, 1'b1, 4'h0}, // R6 pterm
    '{4'd6, 3'd3, 2'd3, 2'b11, 1'b0, 1'b1, 4'h2, 4'h8, 1'b0, 4'h0}, // R6 pterm alt
    '{4'd7, 3'd4, 2'd1, 2'b10, 1'b0, 1'b1, 4'h3, 4'h3, 1'b1, 4'h3}, // R7
    '{4'd7, 3'd4, 2'd0, 2'b10, 1'b0, 1'b1, 4'h6, 4'h9, 1'b0, 4'h6}, // R7
    '{4'd9, 3'd4, 2'd2, 2'b11, 1'b1, 1'b0, 4'h9, 4'hB, 1'b0, 4'h9}, // R9
    '{4'd9, 3'd3, 2'd0, 2'b11, 1'b1, 1'b0, 4'h4, 4'hC, 1'b0, 4'h0}, // R9
    '{4'd8, 3'd5, 2'd0, 2'b11, 1'b1, 1'b1, 4'hC, 4'hD, 1'b0, 4'hC}, // R8
    '{4'd8, 3'd6, 2'd2, 2'b11, 1'b1, 1'b1, 4'h7, 4'hE, 1'b0, 4'h7}, // R8
    '{4'd8, 3'd7, 2'd1, 2'b11, 1'b1, 1'b1, 4'hF, 4'h1, 1'b0, 4'hF}, // R8
    '{4'd8, 3'd0, 2'd2, 2'b11, 1'b1, 1'b1, 4'h1, 4'h2, 1'b0, 4'h1}  // R8
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (2) @(posedge clk_a);
    #1 check("R10 reg in reset", core_in, 4'h0);
    mode = 3'd2;
    #1 check("R10 latch in reset", core_in, 4'h0);
    @(negedge clk_a); #1 rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_a); #1;
      mode = VECS[i].mode; oe_sel = VECS[i].osel; goe = VECS[i].goe;
      pt_oe = VECS[i].pt; toe_n = VECS[i].toe_n;
      pad_in = VECS[i].pin; core_out = VECS[i].cout;
      #1;
      check($sformatf("R%0d vec %0d oe", VECS[i].req, i), {3'b0, pad_oe}, {3'b0, VECS[i].exp_oe});
      check($sformatf("R%0d vec %0d core_in", VECS[i].req, i), core_in, VECS[i].exp_in);
      check($sformatf("R5 vec %0d pad_out", i), pad_out, VECS[i].cout);
    end
    toe_n = 1'b1;

    // R2: registered capture on clk_a
    @(negedge clk_a); #1;
    mode = 3'd1; clk_sel = 1'b0; pad_in = 4'h5;
    #1 check("R2 hold before edge", core_in, 4'h1);
    @(posedge clk_a); #1 check("R2 capture on edge", core_in, 4'h5);
    @(negedge clk_a); #1 pad_in = 4'h9;
    #1 check("R2 hold between edges", core_in, 4'h5);

    // R4: clk_b selected, clk_a ignored
    clk_sel = 1'b1; pad_in = 4'h3;
    @(posedge clk_a); #1 check("R4 unselected clk_a ignored", core_in, 4'h5);
    @(negedge clk_a); #1 clk_b = 1'b1;
    #1 check("R4 capture on clk_b", core_in, 4'h3);
    clk_b = 1'b0; #1;

    // R3: latch on clk_b
    mode = 3'd2; pad_in = 4'h4;
    #1 check("R3 latch holds while low", core_in, 4'h3);
    clk_b = 1'b1;
    #1 check("R3 latch opens", core_in, 4'h4);
    pad_in = 4'h8;
    #1 check("R3 latch transparent", core_in, 4'h8);
    clk_b = 1'b0; #1 pad_in = 4'h2;
    #1 check("R3 latch closed", core_in, 4'h8);

    // R4: latch back on clk_a
    @(negedge clk_a); #1 clk_sel = 1'b0;
    #1 check("R4 latch holds clk_a low", core_in, 4'h8);
    @(posedge clk_a); #1 check("R4 latch follows clk_a high", core_in, 4'h2);

    // R10: asynchronous clear
    mode = 3'd1;
    @(negedge clk_a); #1 check("R10 reg before reset", core_in, 4'h2);
    rst_n = 1'b0;
    #1 check("R10 reg cleared async", core_in, 4'h0);
    mode = 3'd2;
    #1 check("R10 latch cleared async", core_in, 4'h0);
    @(negedge clk_a); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk_a);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule